// File: doc/BRIEF.md
# Hold and Clock-Stop Power Sequencer

This block decides when a small tuner controller suspends its phase-locked loop and when it stops its core clock. It watches three things. The first is an asynchronous hold pin. The second is a software hold-enable flag. The third is a one-cycle strobe that the instruction decoder raises when it executes the clock-stop instruction. From these it drives the following outputs:
- gate enables for the FM and AM frequency-counter inputs
- an output enable for the phase-detector error output
- a run enable for the core oscillator
- a wake pulse
- three pin-override vectors: one for the open-drain outputs, one for the push-pull I/O and one for the port inputs

The pin is first resynchronised. A sequencer with five states then acts on it. POR is the reset state. It moves to RUN unconditionally on the first clock. RUN goes to PLLHOLD when the flag is set and the synchronised pin is low. PLLHOLD goes back to RUN when the flag is cleared or the pin rises. PLLHOLD goes to CLKSTOP when the stop strobe arrives. CLKSTOP leaves only through WAKE, and only when the synchronised pin is high. WAKE lasts one cycle and then goes to RUN. PLLHOLD blocks the counter inputs and floats the error output but keeps the clock running. CLKSTOP also stops the clock and forces every pin class into its safe state.

The block sits on an always-on clock. The oscillator it controls is represented only by `clk_run`.

Top module: `tuner_hold_ctrl`

## Requirements
- R1: The hold pin passes through two synchronising flip-flops, so a level change driven between edges affects the outputs after the third rising edge and not before.
- R2: With `hold_en` = 1 and the synchronised pin low, the sequencer enters PLLHOLD. In PLLHOLD, `fm_gate_en` = 0, `am_gate_en` = 0, `err_oe` = 0 (error output floated) and `clk_run` = 1.
- R3: With `hold_en` = 0, a low hold pin has no effect: the gates stay 1 and `err_oe` stays 1.
- R4: A `stop_strobe` in PLLHOLD moves the sequencer to CLKSTOP on the next edge, where `clk_run` = 0.
- R5: A `stop_strobe` outside PLLHOLD is ignored: `clk_run` stays 1 and the other outputs do not change.
- R6: In CLKSTOP the following outputs take these values:
  - every bit of `od_off` is 1 (open-drain transistors off)
  - every bit of `pp_hiz` is 1 (push-pull pins floated)
  - every bit of `in_block` is 1 (inputs disabled)
  - both gates are 0
  - `err_oe` is 0
- R7: In CLKSTOP, a high synchronised pin moves the sequencer to WAKE. WAKE lasts exactly one cycle with `wake_pulse` = 1 and `clk_run` = 1, and the sequencer then enters RUN.
- R8: Clearing `hold_en` or pulsing `stop_strobe` while in CLKSTOP does not leave CLKSTOP.
- R9: During and directly after reset (POR), the outputs take these values:
  - `od_off` is all ones
  - `pp_hiz` is all ones (I/O pins held as inputs)
  - `in_block` is all zeros
  - both gates are 1
  - `err_oe` is 1
  - `clk_run` is 1
- R10: PLLHOLD returns to RUN on the edge after `hold_en` falls or the synchronised pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hold_pin | input | 1 | Asynchronous hold pin, active low |
| hold_en | input | 1 | Software hold-enable flag |
| stop_strobe | input | 1 | One-cycle clock-stop instruction strobe |
| fm_gate_en | output | 1 | 1 lets the FM counter input through |
| am_gate_en | output | 1 | 1 lets the AM counter input through |
| err_oe | output | 1 | 1 drives the phase-detector error output, 0 floats it |
| clk_run | output | 1 | 1 keeps the core oscillator running |
| wake_pulse | output | 1 | One-cycle pulse on leaving clock stop |
| od_off | output | OD_W | Per-pin force of open-drain outputs to off |
| pp_hiz | output | PP_W | Per-pin force of push-pull pins to high impedance |
| in_block | output | IN_W | Per-pin disable of port inputs |

## Verification
The bench targets the ordering of the entry conditions.

A stop strobe in RUN must be ignored, and one in PLLHOLD must stop the clock. A design that did not check the state would stop the clock from RUN.

The bench counts synchroniser edges. Logic with one stage fewer changes the gates an edge early, and logic with one stage more changes them an edge late.

It clears the flag during clock stop. A design that tied the exit to the flag would wake without the pin rising.

It confirms that the wake pulse is a single cycle. It also checks that the forced pin states appear only in CLKSTOP and in reset.

// File: rtl/hold_pkg.sv
package hold_pkg;

    typedef enum logic [2:0] {
        HS_POR     = 3'd0,
        HS_RUN     = 3'd1,
        HS_PLLHOLD = 3'd2,
        HS_CLKSTOP = 3'd3,
        HS_WAKE    = 3'd4
    } hold_state_e;

    typedef struct packed {
        logic fm_en;
        logic am_en;
        logic err_oe;
        logic clk_run;
        logic wake;
        logic por;
        logic stopped;
    } hold_ctl_t;

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
    parameter int  STAGES    = 2,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
    import hold_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_hi,
    input  logic       hold_en,
    input  logic       stop_strobe,
    output hold_ctl_t  ctl
);

    hold_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_POR;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_POR: begin
                state_d = HS_RUN;
            end
            HS_RUN: begin
                if (hold_en && !pin_hi) begin
                    state_d = HS_PLLHOLD;
                end
            end
            HS_PLLHOLD: begin
                if (!hold_en || pin_hi) begin
                    state_d = HS_RUN;
                end else if (stop_strobe) begin
                    state_d = HS_CLKSTOP;
                end
            end
            HS_CLKSTOP: begin
                if (pin_hi) begin
                    state_d = HS_WAKE;
                end
            end
            HS_WAKE: begin
                state_d = HS_RUN;
            end
            default: begin
                state_d = HS_POR;
            end
        endcase
    end

    // output decode
    always_comb begin
        ctl = '{fm_en: 1'b1, am_en: 1'b1, err_oe: 1'b1, clk_run: 1'b1,
                wake: 1'b0, por: 1'b0, stopped: 1'b0};
        unique case (state_q)
            HS_POR: begin
                ctl.por = 1'b1;
            end
            HS_RUN: begin
            end
            HS_PLLHOLD: begin
                ctl.fm_en  = 1'b0;
                ctl.am_en  = 1'b0;
                ctl.err_oe = 1'b0;
            end
            HS_CLKSTOP: begin
                ctl.fm_en   = 1'b0;
                ctl.am_en   = 1'b0;
                ctl.err_oe  = 1'b0;
                ctl.clk_run = 1'b0;
                ctl.stopped = 1'b1;
            end
            HS_WAKE: begin
                ctl.wake = 1'b1;
            end
            default: begin
                ctl.por = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/hold_pin_force.sv
module hold_pin_force #(
    parameter int W         = 4,
    parameter bit IN_POR    = 1'b0,
    parameter bit IN_STOP   = 1'b1
) (
    input  logic         por,
    input  logic         stopped,
    output logic [W-1:0] force_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            force_o[i] = (por && IN_POR) || (stopped && IN_STOP);
        end
    end

endmodule

// File: rtl/tuner_hold_ctrl.sv
module tuner_hold_ctrl
    import hold_pkg::*;
#(
    parameter int OD_W      = 4,
    parameter int PP_W      = 12,
    parameter int IN_W      = 6,
    parameter int SYNC_STGS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_pin,
    input  logic            hold_en,
    input  logic            stop_strobe,
    output logic            fm_gate_en,
    output logic            am_gate_en,
    output logic            err_oe,
    output logic            clk_run,
    output logic            wake_pulse,
    output logic [OD_W-1:0] od_off,
    output logic [PP_W-1:0] pp_hiz,
    output logic [IN_W-1:0] in_block
);

    logic      pin_hi;
    hold_ctl_t ctl;

    hold_sync #(.STAGES(SYNC_STGS), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (hold_pin),
        .q_sync  (pin_hi)
    );

    hold_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_hi      (pin_hi),
        .hold_en     (hold_en),
        .stop_strobe (stop_strobe),
        .ctl         (ctl)
    );

    hold_pin_force #(.W(OD_W), .IN_POR(1'b1), .IN_STOP(1'b1)) u_od (
        .por(ctl.por), .stopped(ctl.stopped), .force_o(od_off)
    );

    hold_pin_force #(.W(PP_W), .IN_POR(1'b1), .IN_STOP(1'b1)) u_pp (
        .por(ctl.por), .stopped(ctl.stopped), .force_o(pp_hiz)
    );

    hold_pin_force #(.W(IN_W), .IN_POR(1'b0), .IN_STOP(1'b1)) u_in (
        .por(ctl.por), .stopped(ctl.stopped), .force_o(in_block)
    );

    assign fm_gate_en = ctl.fm_en;
    assign am_gate_en = ctl.am_en;
    assign err_oe     = ctl.err_oe;
    assign clk_run    = ctl.clk_run;
    assign wake_pulse = ctl.wake;

endmodule

// File: rtl/tuner_hold_ctrl_chk.sv
module tuner_hold_ctrl_chk #(
    parameter int OD_W = 4,
    parameter int PP_W = 12,
    parameter int IN_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hold_en,
    input logic            stop_strobe,
    input logic            fm_gate_en,
    input logic            am_gate_en,
    input logic            err_oe,
    input logic            clk_run,
    input logic            wake_pulse,
    input logic [OD_W-1:0] od_off,
    input logic [PP_W-1:0] pp_hiz,
    input logic [IN_W-1:0] in_block
);

    // R4: the clock stops only after an enabled stop strobe
    p_stop_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_run && $past(clk_run)) |-> ($past(stop_strobe) && $past(hold_en)));

    // R2: gating starts only with the flag set
    p_hold_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fm_gate_en) |-> $past(hold_en));

    // R6: forced pin states while stopped
    p_stop_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_run |-> ((&od_off) && (&pp_hiz) && (&in_block)
                      && !fm_gate_en && !am_gate_en && !err_oe));

    // R7: wake is a single cycle following clock stop
    p_wake_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    p_wake_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (clk_run && !$past(clk_run)));

    // R8: clock stop is left only through wake
    p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_run |=> (!clk_run || wake_pulse));

endmodule

bind tuner_hold_ctrl tuner_hold_ctrl_chk #(.OD_W(OD_W), .PP_W(PP_W), .IN_W(IN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_en     (hold_en),
    .stop_strobe (stop_strobe),
    .fm_gate_en  (fm_gate_en),
    .am_gate_en  (am_gate_en),
    .err_oe      (err_oe),
    .clk_run     (clk_run),
    .wake_pulse  (wake_pulse),
    .od_off      (od_off),
    .pp_hiz      (pp_hiz),
    .in_block    (in_block)
);

// File: tb/tuner_hold_ctrl_bench.sv
module tuner_hold_ctrl_bench;

    localparam int OD_W = 4;
    localparam int PP_W = 12;
    localparam int IN_W = 6;
    localparam int OW   = 5 + OD_W + PP_W + IN_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_pin = 1'b1;
    logic hold_en = 1'b0;
    logic stop_strobe = 1'b0;
    logic fm_gate_en, am_gate_en, err_oe, clk_run, wake_pulse;
    logic [OD_W-1:0] od_off;
    logic [PP_W-1:0] pp_hiz;
    logic [IN_W-1:0] in_block;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model: 0 POR, 1 RUN, 2 PLLHOLD, 3 CLKSTOP, 4 WAKE
    int m_st = 0;
    logic m_s1 = 1'b1, m_s2 = 1'b1;

    always #4 clk = ~clk;

    tuner_hold_ctrl #(.OD_W(OD_W), .PP_W(PP_W), .IN_W(IN_W)) u_tuner_hold_ctrl (
        .clk(clk), .rst_n(rst_n), .hold_pin(hold_pin), .hold_en(hold_en),
        .stop_strobe(stop_strobe), .fm_gate_en(fm_gate_en), .am_gate_en(am_gate_en),
        .err_oe(err_oe), .clk_run(clk_run), .wake_pulse(wake_pulse),
        .od_off(od_off), .pp_hiz(pp_hiz), .in_block(in_block)
    );

    function automatic logic [OW-1:0] expect_out(input int st);
        logic g, c, w, por, stp;
        g   = (st == 0 || st == 1 || st == 4);
        c   = (st != 3);
        w   = (st == 4);
        por = (st == 0);
        stp = (st == 3);
        return {g, g, g, c, w, {OD_W{por | stp}}, {PP_W{por | stp}}, {IN_W{stp}}};
    endfunction

    function automatic string req_of(input int st);
        case (st)
            0: return "R9";
            2: return "R2";
            3: return "R6";
            4: return "R7";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [OW-1:0] actual_out();
        return {fm_gate_en, am_gate_en, err_oe, clk_run, wake_pulse, od_off, pp_hiz, in_block};
    endfunction

    task automatic check(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (time %0t)", req, act, exp, $time);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (time %0t)", req, act, exp, $time);
        end
    endtask

    // Inputs already set at a negedge; advance one edge, update model, compare.
    task automatic step();
        int nx;
        @(posedge clk);
        nx = m_st;
        case (m_st)
            0: nx = 1;
            1: if (hold_en && !m_s2) nx = 2;
            2: if (!hold_en || m_s2) nx = 1; else if (stop_strobe) nx = 3;
            3: if (m_s2) nx = 4;
            4: nx = 1;
            default: nx = 0;
        endcase
        m_st = nx;
        m_s2 = m_s1;
        m_s1 = hold_pin;
        @(negedge clk);
        check(req_of(m_st), actual_out(), expect_out(m_st));
        stop_strobe = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", actual_out(), expect_out(0));
        rst_n = 1'b1;
        step();
        step();

        // R5: strobe in RUN ignored
        hold_en = 1'b1;
        step();
        stop_strobe = 1'b1;
        step();
        check_bit("R5", clk_run, 1'b1);

        // R1: two-stage synchroniser latency
        hold_pin = 1'b0;
        step();
        step();
        check_bit("R1", fm_gate_en, 1'b1);
        step();
        check_bit("R1", fm_gate_en, 1'b0);
        check_bit("R2", err_oe, 1'b0);
        check_bit("R2", clk_run, 1'b1);

        // R4 / R6: stop
        stop_strobe = 1'b1;
        step();
        check_bit("R4", clk_run, 1'b0);
        check_bit("R6", &{od_off, pp_hiz, in_block}, 1'b1);

        // R8: clearing the flag and pulsing the strobe do not leave stop
        hold_en = 1'b0;
        step();
        stop_strobe = 1'b1;
        step();
        step();
        check_bit("R8", clk_run, 1'b0);

        // R7: wake
        hold_pin = 1'b1;
        step();
        step();
        check_bit("R7", clk_run, 1'b0);
        step();
        check_bit("R7", wake_pulse, 1'b1);
        check_bit("R7", clk_run, 1'b1);
        step();
        check_bit("R7", wake_pulse, 1'b0);

        // R3: flag clear, pin low
        hold_pin = 1'b0;
        repeat (4) step();
        check_bit("R3", fm_gate_en, 1'b1);
        stop_strobe = 1'b1;
        step();
        check_bit("R5", clk_run, 1'b1);

        // R10: leave hold on flag clear
        hold_en = 1'b1;
        step();
        check_bit("R2", am_gate_en, 1'b0);
        hold_en = 1'b0;
        step();
        check_bit("R10", am_gate_en, 1'b1);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 8 == 0)  hold_pin = ~hold_pin;
            if ($urandom % 12 == 0) hold_en = ~hold_en;
            stop_strobe = ($urandom % 4 == 0);
            step();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule